// File: doc/BRIEF.md
# CCD pixel and line timing generator

This block derives the per-pixel control pulses of a CCD image sensor, and the line-level framing around them, from a single master clock. A phase counter splits the master clock into pixel periods of either 24 or 8 clocks. Within each period, three programmable pulses are produced, each with its own on phase and off phase: a sensor reset pulse and two clamp pulses. Two single-clock strobes mark the reference-sample and signal-sample instants.

A pixel-position counter advances once per pixel period. It produces three windows (optical black, active pixels, data pixels) and a one-clock line-end event. The line-end event cuts short any reset or clamp pulse that is still high. The block also watches its own programming for illegal combinations and raises a configuration-error flag. At every line end it latches a status byte that records whether a pause request is pending and whether the configuration is in error.

Every output is registered. Pulses, strobes and windows are computed from the next value of the phase and pixel counters, so each output changes in the same clock as the counter state it belongs to.

Top module: `ccd_timing_gen`

## Requirements
- R1: The pixel period is 24 clocks while `rate_i` is 0 and 8 clocks while it is 1. A strobe programmed to phase p is high in exactly one clock of each period.
- R2: When `rate_i` differs from its value at the previous clock edge, the phase restarts at 0 at that edge. The pixel position is not changed.
- R3: For a pulse with on phase `a` and off phase `b`:
  - when a<b, the pulse is high in the phases p with a<=p<b;
  - when a>b, it is high in the phases p>=a or p<b;
  - when a==b, it stays low.
- R4: In the clock where `line_end_o` is high, `rs_o`, `cp1_o` and `cp2_o` are low. Each of them stays low until its own on phase next comes round, even where its programmed window would still be open.
- R5: `ref_smp_o` is high only in the clocks whose phase equals `ref_ph_i`. `sig_smp_o` is high only in the clocks whose phase equals `sig_ph_i`.
- R6: At the end of the last phase of a pixel whose position is `line_end_pos_i` or greater, the position returns to 0. `line_end_o` is then high for the one clock of phase 0 of that new pixel 0.
- R7: Window membership counts the start position in and the end position out.
  - `blk_win_o` is high for positions in [blk_start, blk_end).
  - `act_win_o` is high for positions in [act_start, dat_end).
  - `dat_win_o` is high for positions in [dat_start, dat_end).
  - All three change in the clock where the phase returns to 0.
- R8: `cfg_err_o` rises one clock after any of the following input conditions. The phase limit is 23 when `rate_i` is 0 and 7 when it is 1.
  - any pulse or strobe phase exceeds the phase limit;
  - `ref_ph_i` and `sig_ph_i` differ by less than 2.
- R9: `cfg_err_o` also rises one clock after any of the following input conditions.
  - `line_end_pos_i` < `dat_end_i` + 20;
  - `dat_start_i` < `act_start_i`;
  - `dat_end_i` < `dat_start_i` + `hdiv_i`.
- R10: `pause_pend_o` is set one clock after `pause_req_i` and cleared one clock after `resume_req_i`. When both are high, the resume wins.
- R11: `status_o` is loaded only at the edge that raises `line_end_o`, and holds its value between those edges. The value loaded is:
  - bit 0: the pause-pending value that `pause_pend_o` takes at that edge;
  - bit 1: the configuration-error value that `cfg_err_o` takes at that edge;
  - bits 7:2: zero.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_i | input | 1 | Pixel rate: 0 = 24 clocks, 1 = 8 clocks |
| rs_on_i | input | 5 | Reset pulse on phase |
| rs_off_i | input | 5 | Reset pulse off phase |
| cp1_on_i | input | 5 | Clamp 1 on phase |
| cp1_off_i | input | 5 | Clamp 1 off phase |
| cp2_on_i | input | 5 | Clamp 2 on phase |
| cp2_off_i | input | 5 | Clamp 2 off phase |
| ref_ph_i | input | 5 | Reference-sample phase |
| sig_ph_i | input | 5 | Signal-sample phase |
| blk_start_i | input | 12 | Optical-black window start position |
| blk_end_i | input | 12 | Optical-black window end position |
| act_start_i | input | 12 | Active window start position |
| dat_start_i | input | 12 | Data window start position |
| dat_end_i | input | 12 | Data and active window end position |
| line_end_pos_i | input | 12 | Last pixel position of a line |
| hdiv_i | input | 12 | Horizontal divider value |
| pause_req_i | input | 1 | Pause request |
| resume_req_i | input | 1 | Resume request |
| rs_o | output | 1 | Sensor reset pulse |
| cp1_o | output | 1 | Clamp pulse 1 |
| cp2_o | output | 1 | Clamp pulse 2 |
| ref_smp_o | output | 1 | Reference-sample strobe |
| sig_smp_o | output | 1 | Signal-sample strobe |
| blk_win_o | output | 1 | Optical-black window |
| act_win_o | output | 1 | Active-pixel window |
| dat_win_o | output | 1 | Data-pixel window |
| line_end_o | output | 1 | One-clock line-end event |
| pause_pend_o | output | 1 | Pause request pending |
| status_o | output | 8 | Status byte latched at line end |
| cfg_err_o | output | 1 | Configuration error |

## Verification
A phase counter that slips shows up within one pixel period: the strobes move off their programmed clocks, and every pulse edge moves with them. A wrong pixel position or a wrong line-end decision shows up at the next window boundary or line end, that is, within one line. A truncation flag that is never set or never cleared corrupts the pulses within the first pixel after a line end. The bench compares every output, clock by clock, with a model built from the requirements, so any such fault is reported within these delays.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  localparam int unsigned N_PULSE   = 3;
  localparam int unsigned PULSE_RS  = 0;
  localparam int unsigned PULSE_CP1 = 1;
  localparam int unsigned PULSE_CP2 = 2;

  localparam int unsigned STAT_W      = 8;
  localparam int unsigned STAT_PAUSE  = 0;
  localparam int unsigned STAT_CFGERR = 1;

  localparam int unsigned LINE_END_MARGIN = 20;
  localparam int unsigned MIN_SAMPLE_GAP  = 2;

endpackage

// File: rtl/ccd_phase_ctr.sv
module ccd_phase_ctr #(
  parameter int unsigned SLOW_DIV = 24,
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned PH_W     = $clog2(SLOW_DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rate_i,
  output logic [PH_W-1:0] ph_d_o,
  output logic            adv_o
);
  import ccd_tg_pkg::*;

  localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic            mode_q;
  logic            mode_chg;
  logic [PH_W-1:0] last_ph;

  always_comb begin
    mode_chg = (rate_i != mode_q);
    last_ph  = (mode_q == RATE_FAST) ? FAST_LAST : SLOW_LAST;
    adv_o    = !mode_chg && (ph_q == last_ph);
    if (mode_chg || adv_o) begin
      ph_d_o = '0;
    end else begin
      ph_d_o = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      mode_q <= RATE_SLOW;
    end else begin
      ph_q   <= ph_d_o;
      mode_q <= rate_i;
    end
  end

endmodule

// File: rtl/ccd_pulse_unit.sv
module ccd_pulse_unit #(
  parameter int unsigned PH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph_d_i,
  input  logic            chop_i,
  input  logic [PH_W-1:0] on_i,
  input  logic [PH_W-1:0] off_i,
  output logic            pulse_o
);

  logic chop_q;
  logic chop_d;
  logic in_win;
  logic pulse_d;

  always_comb begin
    if (on_i < off_i) begin
      in_win = (ph_d_i >= on_i) && (ph_d_i < off_i);
    end else if (on_i > off_i) begin
      in_win = (ph_d_i >= on_i) || (ph_d_i < off_i);
    end else begin
      in_win = 1'b0;
    end

    if (chop_i) begin
      chop_d = 1'b1;
    end else if (ph_d_i == on_i) begin
      chop_d = 1'b0;
    end else begin
      chop_d = chop_q;
    end

    pulse_d = in_win && !chop_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chop_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      chop_q  <= chop_d;
      pulse_o <= pulse_d;
    end
  end

endmodule

// File: rtl/ccd_line_ctr.sv
module ccd_line_ctr #(
  parameter int unsigned PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [PIX_W-1:0] line_end_pos_i,
  input  logic [PIX_W-1:0] blk_start_i,
  input  logic [PIX_W-1:0] blk_end_i,
  input  logic [PIX_W-1:0] act_start_i,
  input  logic [PIX_W-1:0] dat_start_i,
  input  logic [PIX_W-1:0] dat_end_i,
  output logic             leol_d_o,
  output logic             line_end_o,
  output logic             blk_win_o,
  output logic             act_win_o,
  output logic             dat_win_o
);

  logic [PIX_W-1:0] pix_q;
  logic [PIX_W-1:0] pix_d;
  logic             blk_d;
  logic             act_d;
  logic             dat_d;

  always_comb begin
    leol_d_o = adv_i && (pix_q >= line_end_pos_i);
    if (leol_d_o) begin
      pix_d = '0;
    end else if (adv_i) begin
      pix_d = pix_q + 1'b1;
    end else begin
      pix_d = pix_q;
    end
    blk_d = (pix_d >= blk_start_i) && (pix_d < blk_end_i);
    act_d = (pix_d >= act_start_i) && (pix_d < dat_end_i);
    dat_d = (pix_d >= dat_start_i) && (pix_d < dat_end_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q      <= '0;
      line_end_o <= 1'b0;
      blk_win_o  <= 1'b0;
      act_win_o  <= 1'b0;
      dat_win_o  <= 1'b0;
    end else begin
      pix_q      <= pix_d;
      line_end_o <= leol_d_o;
      blk_win_o  <= blk_d;
      act_win_o  <= act_d;
      dat_win_o  <= dat_d;
    end
  end

endmodule

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
  parameter int unsigned SLOW_DIV = 24,
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned PH_W     = 5,
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned N_PH     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rate_i,
  input  logic [N_PH-1:0][PH_W-1:0] phases_i,
  input  logic [PH_W-1:0]           ref_ph_i,
  input  logic [PH_W-1:0]           sig_ph_i,
  input  logic [PIX_W-1:0]          act_start_i,
  input  logic [PIX_W-1:0]          dat_start_i,
  input  logic [PIX_W-1:0]          dat_end_i,
  input  logic [PIX_W-1:0]          line_end_pos_i,
  input  logic [PIX_W-1:0]          hdiv_i,
  output logic                      err_d_o,
  output logic                      err_o
);
  import ccd_tg_pkg::*;

  localparam logic [PH_W-1:0] SLOW_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] FAST_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0] GAP_MIN   = PH_W'(MIN_SAMPLE_GAP);
  localparam logic [PIX_W:0]  MARGIN    = (PIX_W+1)'(LINE_END_MARGIN);

  logic [PH_W-1:0] lim;
  logic [N_PH-1:0] over;
  logic [PH_W-1:0] gap;
  logic            range_err;
  logic            gap_err;
  logic            margin_err;
  logic            start_err;
  logic            len_err;

  always_comb lim = (rate_i == RATE_FAST) ? FAST_LAST : SLOW_LAST;

  for (genvar g = 0; g < N_PH; g++) begin : g_range
    assign over[g] = (phases_i[g] > lim);
  end

  always_comb begin
    range_err  = |over;
    gap        = (ref_ph_i >= sig_ph_i) ? (ref_ph_i - sig_ph_i) : (sig_ph_i - ref_ph_i);
    gap_err    = (gap < GAP_MIN);
    margin_err = ({1'b0, line_end_pos_i} < ({1'b0, dat_end_i} + MARGIN));
    start_err  = (dat_start_i < act_start_i);
    len_err    = ({1'b0, dat_end_i} < ({1'b0, dat_start_i} + {1'b0, hdiv_i}));
    err_d_o    = range_err || gap_err || margin_err || start_err || len_err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= 1'b0;
    end else begin
      err_o <= err_d_o;
    end
  end

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int unsigned SLOW_DIV = 24,
  parameter int unsigned FAST_DIV = 8,
  parameter int unsigned PH_W     = 5,
  parameter int unsigned PIX_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rate_i,
  input  logic [PH_W-1:0]  rs_on_i,
  input  logic [PH_W-1:0]  rs_off_i,
  input  logic [PH_W-1:0]  cp1_on_i,
  input  logic [PH_W-1:0]  cp1_off_i,
  input  logic [PH_W-1:0]  cp2_on_i,
  input  logic [PH_W-1:0]  cp2_off_i,
  input  logic [PH_W-1:0]  ref_ph_i,
  input  logic [PH_W-1:0]  sig_ph_i,
  input  logic [PIX_W-1:0] blk_start_i,
  input  logic [PIX_W-1:0] blk_end_i,
  input  logic [PIX_W-1:0] act_start_i,
  input  logic [PIX_W-1:0] dat_start_i,
  input  logic [PIX_W-1:0] dat_end_i,
  input  logic [PIX_W-1:0] line_end_pos_i,
  input  logic [PIX_W-1:0] hdiv_i,
  input  logic             pause_req_i,
  input  logic             resume_req_i,
  output logic             rs_o,
  output logic             cp1_o,
  output logic             cp2_o,
  output logic             ref_smp_o,
  output logic             sig_smp_o,
  output logic             blk_win_o,
  output logic             act_win_o,
  output logic             dat_win_o,
  output logic             line_end_o,
  output logic             pause_pend_o,
  output logic [7:0]       status_o,
  output logic             cfg_err_o
);
  import ccd_tg_pkg::*;

  localparam int unsigned N_PH = 2 * N_PULSE + 2;

  logic [PH_W-1:0]                 ph_d;
  logic                            adv;
  logic                            leol_d;
  logic                            err_d;
  logic [N_PULSE-1:0][PH_W-1:0]    on_arr;
  logic [N_PULSE-1:0][PH_W-1:0]    off_arr;
  logic [N_PULSE-1:0]              pulse;
  logic [N_PH-1:0][PH_W-1:0]       all_ph;
  logic                            ref_d;
  logic                            sig_d;
  logic                            pend_d;
  logic [STAT_W-1:0]               stat_d;

  ccd_phase_ctr #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .PH_W     (PH_W)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_i),
    .ph_d_o (ph_d),
    .adv_o  (adv)
  );

  ccd_line_ctr #(
    .PIX_W (PIX_W)
  ) u_line (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .adv_i          (adv),
    .line_end_pos_i (line_end_pos_i),
    .blk_start_i    (blk_start_i),
    .blk_end_i      (blk_end_i),
    .act_start_i    (act_start_i),
    .dat_start_i    (dat_start_i),
    .dat_end_i      (dat_end_i),
    .leol_d_o       (leol_d),
    .line_end_o     (line_end_o),
    .blk_win_o      (blk_win_o),
    .act_win_o      (act_win_o),
    .dat_win_o      (dat_win_o)
  );

  always_comb begin
    on_arr[PULSE_RS]   = rs_on_i;
    off_arr[PULSE_RS]  = rs_off_i;
    on_arr[PULSE_CP1]  = cp1_on_i;
    off_arr[PULSE_CP1] = cp1_off_i;
    on_arr[PULSE_CP2]  = cp2_on_i;
    off_arr[PULSE_CP2] = cp2_off_i;
    for (int k = 0; k < N_PULSE; k++) begin
      all_ph[2*k]     = on_arr[k];
      all_ph[2*k + 1] = off_arr[k];
    end
    all_ph[N_PH-2] = ref_ph_i;
    all_ph[N_PH-1] = sig_ph_i;
  end

  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    ccd_pulse_unit #(
      .PH_W (PH_W)
    ) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ph_d_i  (ph_d),
      .chop_i  (leol_d),
      .on_i    (on_arr[g]),
      .off_i   (off_arr[g]),
      .pulse_o (pulse[g])
    );
  end

  assign rs_o  = pulse[PULSE_RS];
  assign cp1_o = pulse[PULSE_CP1];
  assign cp2_o = pulse[PULSE_CP2];

  ccd_cfg_check #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .PH_W     (PH_W),
    .PIX_W    (PIX_W),
    .N_PH     (N_PH)
  ) u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rate_i         (rate_i),
    .phases_i       (all_ph),
    .ref_ph_i       (ref_ph_i),
    .sig_ph_i       (sig_ph_i),
    .act_start_i    (act_start_i),
    .dat_start_i    (dat_start_i),
    .dat_end_i      (dat_end_i),
    .line_end_pos_i (line_end_pos_i),
    .hdiv_i         (hdiv_i),
    .err_d_o        (err_d),
    .err_o          (cfg_err_o)
  );

  always_comb begin
    ref_d = (ph_d == ref_ph_i);
    sig_d = (ph_d == sig_ph_i);
    if (resume_req_i) begin
      pend_d = 1'b0;
    end else if (pause_req_i) begin
      pend_d = 1'b1;
    end else begin
      pend_d = pause_pend_o;
    end
    stat_d              = '0;
    stat_d[STAT_PAUSE]  = pend_d;
    stat_d[STAT_CFGERR] = err_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_smp_o    <= 1'b0;
      sig_smp_o    <= 1'b0;
      pause_pend_o <= 1'b0;
      status_o     <= '0;
    end else begin
      ref_smp_o    <= ref_d;
      sig_smp_o    <= sig_d;
      pause_pend_o <= pend_d;
      if (leol_d) begin
        status_o <= stat_d;
      end
    end
  end

endmodule

// File: rtl/ccd_timing_gen_chk.sv
module ccd_timing_gen_chk #(
  parameter int unsigned PH_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            line_end_o,
  input logic            rs_o,
  input logic            cp1_o,
  input logic            cp2_o,
  input logic [PH_W-1:0] ref_ph_i,
  input logic [PH_W-1:0] sig_ph_i,
  input logic            cfg_err_o,
  input logic            resume_req_i,
  input logic            pause_pend_o,
  input logic [7:0]      status_o
);

  AST_LINE_END_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> !line_end_o); // R6

  AST_CHOP_AT_LINE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |-> (!rs_o && !cp1_o && !cp2_o)); // R4

  AST_SAMPLE_CLASH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ph_i == sig_ph_i) |=> cfg_err_o); // R8

  AST_RESUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_i |=> !pause_pend_o); // R10

  AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |-> $stable(status_o)); // R11

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:2] == 6'd0); // R11

endmodule

bind ccd_timing_gen ccd_timing_gen_chk #(.PH_W(PH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_end_o   (line_end_o),
  .rs_o         (rs_o),
  .cp1_o        (cp1_o),
  .cp2_o        (cp2_o),
  .ref_ph_i     (ref_ph_i),
  .sig_ph_i     (sig_ph_i),
  .cfg_err_o    (cfg_err_o),
  .resume_req_i (resume_req_i),
  .pause_pend_o (pause_pend_o),
  .status_o     (status_o)
);

// File: tb/ccd_timing_gen_tb.sv
module ccd_timing_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rate;
  logic [4:0]  rs_on, rs_off, cp1_on, cp1_off, cp2_on, cp2_off, ref_ph, sig_ph;
  logic [11:0] blk_s, blk_e, act_s, dat_s, dat_e, lep, hdiv;
  logic        pause_req, resume_req;
  logic        rs, cp1, cp2, ref_smp, sig_smp, blk_w, act_w, dat_w, line_end, pend, cfg_err;
  logic [7:0]  status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model state
  int m_ph, m_mode, m_pix;
  bit m_chop [3];
  bit e_pulse [3];
  bit e_ref, e_sig, e_blk, e_act, e_dat, e_le, e_pend, e_err;
  int e_stat;

  always #10 clk = ~clk;

  ccd_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate),
    .rs_on_i(rs_on), .rs_off_i(rs_off), .cp1_on_i(cp1_on), .cp1_off_i(cp1_off),
    .cp2_on_i(cp2_on), .cp2_off_i(cp2_off), .ref_ph_i(ref_ph), .sig_ph_i(sig_ph),
    .blk_start_i(blk_s), .blk_end_i(blk_e), .act_start_i(act_s), .dat_start_i(dat_s),
    .dat_end_i(dat_e), .line_end_pos_i(lep), .hdiv_i(hdiv),
    .pause_req_i(pause_req), .resume_req_i(resume_req),
    .rs_o(rs), .cp1_o(cp1), .cp2_o(cp2), .ref_smp_o(ref_smp), .sig_smp_o(sig_smp),
    .blk_win_o(blk_w), .act_win_o(act_w), .dat_win_o(dat_w), .line_end_o(line_end),
    .pause_pend_o(pend), .status_o(status), .cfg_err_o(cfg_err)
  );

  task automatic check(string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // R3: pulse membership of phase p for on phase a, off phase b
  function automatic bit in_pulse(int p, int a, int b);
    if (a < b) return (p >= a) && (p < b);
    if (a > b) return (p >= a) || (p < b);
    return 1'b0;
  endfunction

  // R8, R9: configuration legality
  function automatic bit cfg_bad();
    int lim = rate ? 7 : 23;
    int gap = (ref_ph > sig_ph) ? ref_ph - sig_ph : sig_ph - ref_ph;
    bit b = 1'b0;
    if (rs_on > lim || rs_off > lim || cp1_on > lim || cp1_off > lim) b = 1'b1;
    if (cp2_on > lim || cp2_off > lim || ref_ph > lim || sig_ph > lim) b = 1'b1;
    if (gap < 2) b = 1'b1;
    if (int'(lep) < int'(dat_e) + 20) b = 1'b1;
    if (dat_s < act_s) b = 1'b1;
    if (int'(dat_e) < int'(dat_s) + int'(hdiv)) b = 1'b1;
    return b;
  endfunction

  task automatic model_step();
    int  last = (m_mode != 0) ? 7 : 23;
    bit  chg  = (int'(rate) != m_mode);
    bit  adv  = !chg && (m_ph == last);
    bit  leol = adv && (m_pix >= int'(lep));
    int  nph  = (chg || adv) ? 0 : m_ph + 1;
    int  on_v [3];
    int  off_v [3];
    bit  npend;
    on_v[0] = rs_on;  off_v[0] = rs_off;
    on_v[1] = cp1_on; off_v[1] = cp1_off;
    on_v[2] = cp2_on; off_v[2] = cp2_off;
    if (leol) m_pix = 0;
    else if (adv) m_pix = m_pix + 1;
    for (int k = 0; k < 3; k++) begin
      if (leol) m_chop[k] = 1'b1;
      else if (nph == on_v[k]) m_chop[k] = 1'b0;
      e_pulse[k] = in_pulse(nph, on_v[k], off_v[k]) && !m_chop[k];
    end
    e_ref = (nph == int'(ref_ph));
    e_sig = (nph == int'(sig_ph));
    e_blk = (m_pix >= int'(blk_s)) && (m_pix < int'(blk_e));
    e_act = (m_pix >= int'(act_s)) && (m_pix < int'(dat_e));
    e_dat = (m_pix >= int'(dat_s)) && (m_pix < int'(dat_e));
    e_le  = leol;
    npend = resume_req ? 1'b0 : (pause_req ? 1'b1 : e_pend);
    e_err = cfg_bad();
    if (leol) e_stat = {npend ? 1 : 0} + (e_err ? 2 : 0);
    e_pend = npend;
    m_ph   = nph;
    m_mode = rate;
  endtask

  task automatic compare();
    check("R3 R4", "rs",  rs,  e_pulse[0]);
    check("R3 R4", "cp1", cp1, e_pulse[1]);
    check("R3 R4", "cp2", cp2, e_pulse[2]);
    check("R1 R2 R5", "ref_smp", ref_smp, e_ref);
    check("R1 R2 R5", "sig_smp", sig_smp, e_sig);
    check("R7", "windows", {blk_w, act_w, dat_w}, {e_blk, e_act, e_dat});
    check("R6", "line_end", line_end, e_le);
    check("R8 R9", "cfg_err", cfg_err, e_err);
    check("R10", "pause_pend", pend, e_pend);
    check("R11", "status", status, e_stat);
  endtask

  task automatic rand_cfg(bit allow_bad);
    int lim = rate ? 7 : 23;
    int wide = (allow_bad && ($urandom % 8 == 0)) ? 31 : lim;
    rs_on  = 5'($urandom % (wide + 1)); rs_off  = 5'($urandom % (lim + 1));
    cp1_on = 5'($urandom % (lim + 1));  cp1_off = 5'($urandom % (lim + 1));
    cp2_on = 5'($urandom % (lim + 1));  cp2_off = 5'($urandom % (lim + 1));
    ref_ph = 5'($urandom % (lim + 1));  sig_ph  = 5'($urandom % (lim + 1));
    blk_s  = 12'($urandom % 3);         blk_e   = blk_s + 12'($urandom % 4);
    act_s  = 12'(2 + $urandom % 3);     dat_s   = act_s + 12'($urandom % 3);
    hdiv   = 12'(1 + $urandom % 4);     dat_e   = dat_s + hdiv + 12'($urandom % 5);
    lep    = dat_e + 12'(20 + $urandom % 4);
    if (allow_bad && ($urandom % 6 == 0)) lep = dat_e + 12'(19);
    if (allow_bad && ($urandom % 6 == 0)) dat_s = act_s - 12'd1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      pause_req  = ($urandom % 150 == 0);
      resume_req = ($urandom % 240 == 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rate = 1'b0; pause_req = 1'b0; resume_req = 1'b0;
    // directed: wrapping RS, empty CP1 (on==off), normal CP2
    rs_on = 5'd20; rs_off = 5'd3; cp1_on = 5'd5; cp1_off = 5'd5; cp2_on = 5'd2; cp2_off = 5'd10;
    ref_ph = 5'd12; sig_ph = 5'd18;
    blk_s = 12'd0; blk_e = 12'd2; act_s = 12'd2; dat_s = 12'd3; hdiv = 12'd2;
    dat_e = 12'd8; lep = 12'd28;
    m_ph = 0; m_mode = 0; m_pix = 0;
    for (int k = 0; k < 3; k++) begin m_chop[k] = 1'b0; e_pulse[k] = 1'b0; end
    e_ref = 0; e_sig = 0; e_blk = 0; e_act = 0; e_dat = 0; e_le = 0; e_pend = 0; e_err = 0;
    e_stat = 0;
    repeat (3) @(negedge clk);
    // R12: reset values at the ports
    check("R12", "outputs in reset",
          {rs, cp1, cp2, ref_smp, sig_smp, blk_w, act_w, dat_w, line_end, pend, cfg_err}, 0);
    check("R12", "status in reset", status, 0);
    rst_n = 1'b1;
    run(2000);
    // directed: pause then resume, both at once (resume wins)
    pause_req = 1'b1; run(1); pause_req = 1'b0; run(700);
    pause_req = 1'b1; resume_req = 1'b1; run(1);
    // directed: sample phases too close and line-end margin short
    ref_ph = 5'd4; sig_ph = 5'd5; lep = 12'd27; run(1500);
    ref_ph = 5'd4; sig_ph = 5'd6; lep = 12'd28; run(1500);
    // directed: fast rate with a truncated wrapping pulse
    rate = 1'b1; rs_on = 5'd6; rs_off = 5'd2; cp2_on = 5'd0; cp2_off = 5'd4;
    ref_ph = 5'd1; sig_ph = 5'd5; cp1_on = 5'd7; cp1_off = 5'd1; run(1500);
    rate = 1'b0; run(1000);
    // constrained random segments
    for (int s = 0; s < 40; s++) begin
      if ($urandom % 4 == 0) rate = ~rate;
      rand_cfg(1'b1);
      run(400 + int'($urandom % 600));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule